// File: doc/BRIEF.md
# Low-Speed USB Packet Receiver

This block receives low-speed USB packets from the D+ and D- line inputs. Its clock runs at exactly ten times the bit rate, so each bit lasts ten clock cycles. Both line inputs first pass through a two-flop synchronizer. A state machine then hunts for the sync pattern and locks its bit timing to a J-to-K edge. Reception starts only once the double K that closes sync has been confirmed.

Once locked, the block samples each bit at mid-bit. It decodes the NRZI line code, drops stuffed bits inline and assembles the data into bytes, least significant bit first. Each completed byte is presented with a one-cycle strobe for the surrounding logic to write into its buffer. A running byte count is kept, and the packet ends on SE0. Two error flags report the failure cases: one when the buffer budget is exceeded, and one when no sync edge arrives in time.

States:
- ST_IDLE: waits for activity.
- ST_WAIT_J: inside a K, waiting for J.
- ST_WAIT_K: waiting for the J-to-K edge.
- ST_CHECK2K: samples the bit after that edge.
- ST_RECV: receives data bits.
- ST_DRAIN: ignores the rest of an aborted packet.

Transitions:
- activity: ST_IDLE to ST_WAIT_J on K.
- seen_j: ST_WAIT_J to ST_WAIT_K on J.
- edge_k: ST_WAIT_K to ST_CHECK2K on K.
- double_k: ST_CHECK2K to ST_RECV when the check sample is K.
- retry: ST_CHECK2K to ST_WAIT_K when the check sample is not K.
- sync_timeout: ST_WAIT_J or ST_WAIT_K to ST_IDLE after two bit times without the awaited level.
- end_of_packet: ST_RECV to ST_IDLE on a terminating SE0.
- overflow: ST_RECV to ST_DRAIN when one byte too many completes.
- drained: ST_DRAIN to ST_IDLE on SE0.

Top module: `lsrx_packet_rx`

## Requirements
- R1: The line state J is D+=0, D-=1; K is D+=1, D-=0; SE0 is both low. After reset every output is zero.
- R2: Each J-to-K edge is checked by sampling the following bit, 15 cycles after the edge is seen. If that bit is K, reception starts. Otherwise the block returns to waiting for a K edge, so any number of extra K,J pairs before the final double K is accepted.
- R3: In ST_WAIT_J or ST_WAIT_K, if the awaited level does not appear within 2*CYC_PER_BIT cycles, err_sync pulses for one cycle, the block goes idle and no byte is delivered.
- R4: Data bits are sampled every CYC_PER_BIT cycles. The first data bit is sampled one bit period after the second K of sync.
- R5: NRZI decoding yields 1 when a sample equals the previous one and 0 when it differs. The first data bit is compared against the closing K of sync.
- R6: After RUN_LEN (6) consecutive decoded 1s, the next bit is discarded. The run starts at 1 (the closing K), carries across byte boundaries and is cleared by any decoded 0.
- R7: Bytes are assembled LSB first. Each byte appears on rx_byte with a one-cycle rx_byte_valid pulse, and rx_byte_count rises by one with it. rx_byte_count returns to 0 when a new packet's sync completes.
- R8: SE0 sampled at data bit positions 1 to 7, or in a stuffed-bit slot, ends the packet. pkt_done pulses for one cycle and a partial byte is discarded.
- R9: SE0 sampled at data bit position 0 of a byte does not end the packet. It is decoded as a K level.
- R10: When byte number BUF_BYTES+1 completes, it is not delivered and err_overflow pulses. The rest of the packet is ignored until SE0, with no pkt_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, ten times the bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_dp | input | 1 | D+ line level, asynchronous |
| line_dm | input | 1 | D- line level, asynchronous |
| rx_byte | output | 8 | Received byte |
| rx_byte_valid | output | 1 | One-cycle strobe for rx_byte |
| rx_byte_count | output | $clog2(BUF_BYTES+1) | Bytes delivered in the current or last packet |
| pkt_done | output | 1 | One-cycle pulse at end of packet |
| err_overflow | output | 1 | One-cycle pulse when the byte budget is exceeded |
| err_sync | output | 1 | One-cycle pulse when the sync hunt times out |

## Verification
The assertions take for granted that the line holds each level for whole bit periods of exactly CYC_PER_BIT cycles. They also assume SE0 appears only where a packet ends or in a bit-0 slot, and that the line is never driven with both lines high. The stimulus keeps within this by building every waveform from a bit-level encoder. The encoder drives ten-cycle bits, applies NRZI and stuffing exactly as the requirements state, and closes each packet with two bits of SE0 followed by idle J. The only deliberate departures are a bit-0 SE0 substitution, a mid-byte SE0 and a sync hunt that stays in J.

// File: rtl/lsrx_pkg.sv
package lsrx_pkg;

    // Encoded as {D+, D-}
    typedef enum logic [1:0] {
        LN_SE0 = 2'b00,
        LN_J   = 2'b01,
        LN_K   = 2'b10,
        LN_SE1 = 2'b11
    } line_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_J,
        ST_WAIT_K,
        ST_CHECK2K,
        ST_RECV,
        ST_DRAIN
    } rx_state_t;

endpackage

// File: rtl/lsrx_line_sync.sv
module lsrx_line_sync
    import lsrx_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  dp_raw,
    input  logic  dm_raw,
    output line_t line_o
);

    logic [STAGES-1:0] dp_q;
    logic [STAGES-1:0] dm_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        dp_q[0] <= 1'b0;
                        dm_q[0] <= 1'b1;
                    end else begin
                        dp_q[0] <= dp_raw;
                        dm_q[0] <= dm_raw;
                    end
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        dp_q[s] <= 1'b0;
                        dm_q[s] <= 1'b1;
                    end else begin
                        dp_q[s] <= dp_q[s-1];
                        dm_q[s] <= dm_q[s-1];
                    end
                end
            end
        end
    endgenerate

    assign line_o = line_t'({dp_q[STAGES-1], dm_q[STAGES-1]});

endmodule

// File: rtl/lsrx_bit_decoder.sv
module lsrx_bit_decoder #(
    parameter int RUN_LEN = 6,
    parameter int BYTE_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              smp_i,
    input  logic              lvl_i,
    input  logic              se0_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic              byte_stb_o,
    output logic              eop_o
);

    localparam int IDX_W = $clog2(BYTE_W);
    localparam int RUN_W = $clog2(RUN_LEN + 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BYTE_W - 1);
    localparam logic [RUN_W-1:0] RUN_MAX  = RUN_W'(RUN_LEN);

    logic              prev_q;
    logic [RUN_W-1:0]  run_q;
    logic [IDX_W-1:0]  idx_q;
    logic [BYTE_W-1:0] shr_q;

    logic              stuff_slot;
    logic              dbit;
    logic [BYTE_W-1:0] shifted;
    logic              bit0_slot;

    always_comb begin
        stuff_slot = (run_q == RUN_MAX);
        dbit       = (lvl_i == prev_q);
        shifted    = {dbit, shr_q[BYTE_W-1:1]};
        bit0_slot  = (idx_q == '0) && !stuff_slot;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q     <= 1'b0;
            run_q      <= '0;
            idx_q      <= '0;
            shr_q      <= '0;
            byte_o     <= '0;
            byte_stb_o <= 1'b0;
            eop_o      <= 1'b0;
        end else begin
            byte_stb_o <= 1'b0;
            eop_o      <= 1'b0;
            if (start_i) begin
                prev_q <= 1'b0;             // closing K of sync (D- low)
                run_q  <= RUN_W'(1);
                idx_q  <= '0;
                shr_q  <= '0;
            end else if (smp_i) begin
                if (se0_i && !bit0_slot) begin
                    eop_o <= 1'b1;
                end else if (stuff_slot) begin
                    run_q  <= '0;
                    prev_q <= lvl_i;
                end else begin
                    prev_q <= lvl_i;
                    shr_q  <= shifted;
                    run_q  <= dbit ? run_q + RUN_W'(1) : '0;
                    if (idx_q == IDX_LAST) begin
                        idx_q      <= '0;
                        byte_stb_o <= 1'b1;
                        byte_o     <= shifted;
                    end else begin
                        idx_q <= idx_q + IDX_W'(1);
                    end
                end
            end
        end
    end

    // R6: the ones run never passes the stuffing limit
    a_r6_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_MAX);

    // R4: samples are spaced, never back to back
    a_r4_sample_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        smp_i |=> !smp_i);

    // R9: SE0 in a bit-0 slot never ends the packet
    a_r9_bit0_se0_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_i && !start_i && se0_i && bit0_slot) |=> !eop_o);

endmodule

// File: rtl/lsrx_packet_rx.sv
module lsrx_packet_rx
    import lsrx_pkg::*;
#(
    parameter int CYC_PER_BIT = 10,
    parameter int BUF_BYTES   = 8,
    parameter int RUN_LEN     = 6,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = $clog2(BUF_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_dp,
    input  logic             line_dm,
    output logic [7:0]       rx_byte,
    output logic             rx_byte_valid,
    output logic [CNT_W-1:0] rx_byte_count,
    output logic             pkt_done,
    output logic             err_overflow,
    output logic             err_sync
);

    localparam int SYNC_LIMIT = 2 * CYC_PER_BIT;
    localparam int PH_W       = $clog2(SYNC_LIMIT + 1);
    localparam logic [PH_W-1:0] PH_BIT_END = PH_W'(CYC_PER_BIT - 1);
    localparam logic [PH_W-1:0] PH_CHECK   = PH_W'(CYC_PER_BIT + CYC_PER_BIT / 2 - 1);
    localparam logic [PH_W-1:0] PH_TIMEOUT = PH_W'(SYNC_LIMIT - 1);
    localparam logic [PH_W-1:0] PH_MAX     = PH_W'(SYNC_LIMIT);
    localparam logic [CNT_W-1:0] CNT_FULL  = CNT_W'(BUF_BYTES);

    line_t      line;
    rx_state_t  state, nxt;
    logic [PH_W-1:0] tick;

    logic       smp_stb;
    logic       chk_stb;
    logic       timeout;
    logic       sync_ok;
    logic [7:0] dec_byte;
    logic       dec_stb;
    logic       dec_eop;

    lsrx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .dp_raw (line_dp),
        .dm_raw (line_dm),
        .line_o (line)
    );

    always_comb begin
        smp_stb = (state == ST_RECV) && (tick == PH_BIT_END);
        chk_stb = (state == ST_CHECK2K) && (tick == PH_CHECK);
        timeout = ((state == ST_WAIT_J) || (state == ST_WAIT_K)) && (tick == PH_TIMEOUT);
        sync_ok = chk_stb && (line == LN_K);
    end

    lsrx_bit_decoder #(.RUN_LEN(RUN_LEN), .BYTE_W(8)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (sync_ok),
        .smp_i      (smp_stb),
        .lvl_i      (line[0]),
        .se0_i      (line == LN_SE0),
        .byte_o     (dec_byte),
        .byte_stb_o (dec_stb),
        .eop_o      (dec_eop)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (line == LN_K) nxt = ST_WAIT_J;
            ST_WAIT_J:  if (line == LN_J) nxt = ST_WAIT_K;
                        else if (timeout) nxt = ST_IDLE;
            ST_WAIT_K:  if (line == LN_K) nxt = ST_CHECK2K;
                        else if (timeout) nxt = ST_IDLE;
            ST_CHECK2K: if (chk_stb) nxt = (line == LN_K) ? ST_RECV : ST_WAIT_K;
            ST_RECV:    if (dec_eop) nxt = ST_IDLE;
                        else if (dec_stb && rx_byte_count == CNT_FULL) nxt = ST_DRAIN;
            ST_DRAIN:   if (line == LN_SE0) nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // outputs and timing counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick          <= '0;
            rx_byte       <= '0;
            rx_byte_valid <= 1'b0;
            rx_byte_count <= '0;
            pkt_done      <= 1'b0;
            err_overflow  <= 1'b0;
            err_sync      <= 1'b0;
        end else begin
            rx_byte_valid <= 1'b0;
            pkt_done      <= 1'b0;
            err_overflow  <= 1'b0;
            err_sync      <= 1'b0;

            if (nxt != state)                         tick <= '0;
            else if (state == ST_RECV && tick == PH_BIT_END) tick <= '0;
            else if (tick != PH_MAX)                  tick <= tick + PH_W'(1);

            if (timeout && nxt == ST_IDLE) err_sync <= 1'b1;
            if (sync_ok) rx_byte_count <= '0;

            if (state == ST_RECV) begin
                if (dec_eop) begin
                    pkt_done <= 1'b1;
                end else if (dec_stb) begin
                    if (rx_byte_count == CNT_FULL) begin
                        err_overflow <= 1'b1;
                    end else begin
                        rx_byte       <= dec_byte;
                        rx_byte_valid <= 1'b1;
                        rx_byte_count <= rx_byte_count + CNT_W'(1);
                    end
                end
            end
        end
    end

    // R7: every delivered byte advances the count by exactly one
    a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        rx_byte_valid |-> (rx_byte_count == $past(rx_byte_count) + CNT_W'(1)));

    // R10: the count never exceeds the buffer budget
    a_r10_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
        rx_byte_count <= CNT_FULL);

    // R10: overflow only reported with a full buffer
    a_r10_ovf_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        err_overflow |-> (rx_byte_count == CNT_FULL));

    // R8: status pulses are mutually exclusive
    a_r8_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_byte_valid, pkt_done, err_overflow, err_sync}));

    // R2: reception begins only after a K check sample
    a_r2_recv_after_check: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RECV && $past(state) != ST_RECV) |-> ($past(state) == ST_CHECK2K));

endmodule

// File: tb/test_lsrx_packet_rx.sv
module test_lsrx_packet_rx;

    localparam int CYC  = 10;
    localparam int BUFN = 8;
    localparam int CW   = $clog2(BUFN + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          line_dp = 1'b0;
    logic          line_dm = 1'b1;
    logic [7:0]    rx_byte;
    logic          rx_byte_valid;
    logic [CW-1:0] rx_byte_count;
    logic          pkt_done;
    logic          err_overflow;
    logic          err_sync;

    always #2 clk = ~clk;   // 250 MHz

    lsrx_packet_rx #(.CYC_PER_BIT(CYC), .BUF_BYTES(BUFN)) i_lsrx_packet_rx (
        .clk           (clk),
        .rst_n         (rst_n),
        .line_dp       (line_dp),
        .line_dm       (line_dm),
        .rx_byte       (rx_byte),
        .rx_byte_valid (rx_byte_valid),
        .rx_byte_count (rx_byte_count),
        .pkt_done      (pkt_done),
        .err_overflow  (err_overflow),
        .err_sync      (err_sync)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    // monitor
    int         n_bytes = 0, n_done = 0, n_ovf = 0, n_serr = 0;
    logic [7:0] got [0:255];
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_byte_valid) begin
                got[n_bytes[7:0]] <= rx_byte;
                n_bytes <= n_bytes + 1;
            end
            if (pkt_done)     n_done <= n_done + 1;
            if (err_overflow) n_ovf  <= n_ovf + 1;
            if (err_sync)     n_serr <= n_serr + 1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // bench-side encoder state: D- level (1 = J) and ones run
    logic lvl;
    int   run;

    task automatic drive(input logic dp, input logic dm);
        line_dp = dp;
        line_dm = dm;
        repeat (CYC) @(negedge clk);
    endtask

    task automatic drive_lvl(input logic dm_lvl, input bit se0);
        if (se0) drive(1'b0, 1'b0);
        else     drive(~dm_lvl, dm_lvl);
    endtask

    task automatic idle_bits(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 1'b1);
    endtask

    task automatic send_sync(input int extra_pairs);
        for (int i = 0; i < extra_pairs; i++) begin
            drive_lvl(1'b0, 0);
            drive_lvl(1'b1, 0);
        end
        for (int i = 0; i < 3; i++) begin
            drive_lvl(1'b0, 0);
            drive_lvl(1'b1, 0);
        end
        drive_lvl(1'b0, 0);
        drive_lvl(1'b0, 0);
        lvl = 1'b0;
        run = 1;
    endtask

    task automatic send_bit(input logic b, input bit se0);
        if (!b) lvl = ~lvl;
        drive_lvl(lvl, se0);
        run = b ? run + 1 : 0;
        if (run == 6) begin
            lvl = ~lvl;
            drive_lvl(lvl, 0);
            run = 0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input bit se0_bit0);
        for (int i = 0; i < 8; i++) send_bit(b[i], se0_bit0 && i == 0);
    endtask

    task automatic send_eop();
        drive(1'b0, 1'b0);
        drive(1'b0, 1'b0);
        idle_bits(4);
    endtask

    task automatic check_bytes(input string req, input int base, input logic [7:0] exp [],
                               input int n);
        for (int i = 0; i < n; i++) check(req, int'(got[(base + i) % 256]), int'(exp[i]));
    endtask

    task automatic t_reset();
        check("R1 reset byte_valid", int'(rx_byte_valid), 0);
        check("R1 reset count", int'(rx_byte_count), 0);
        check("R1 reset flags", int'({pkt_done, err_overflow, err_sync}), 0);
    endtask

    task automatic t_packet(input string req, input int pre, input logic [7:0] d []);
        int b0 = n_bytes, d0 = n_done;
        send_sync(pre);
        foreach (d[i]) send_byte(d[i], 0);
        send_eop();
        check({req, " byte total"}, n_bytes - b0, d.size());
        check_bytes({req, " byte value"}, b0, d, d.size());
        check({req, " pkt_done R8"}, n_done - d0, 1);
        check({req, " count R7"}, int'(rx_byte_count), d.size());
    endtask

    task automatic t_sync_error();
        int b0 = n_bytes, s0 = n_serr;
        drive_lvl(1'b0, 0);
        idle_bits(4);
        check("R3 err_sync pulses", n_serr - s0, 1);
        check("R3 no bytes", n_bytes - b0, 0);
    endtask

    task automatic t_se0_bit0();
        logic [7:0] d [] = '{8'h00, 8'hA5, 8'h11};
        int b0 = n_bytes, d0 = n_done;
        send_sync(0);
        send_byte(d[0], 0);
        send_byte(d[1], 1);      // bit 0 of byte 1 is K, replaced by SE0
        send_byte(d[2], 0);
        send_eop();
        check("R9 bytes intact", n_bytes - b0, 3);
        check_bytes("R9 byte value", b0, d, 3);
        check("R9 single pkt_done", n_done - d0, 1);
    endtask

    task automatic t_mid_se0();
        logic [7:0] d [] = '{8'h3C};
        int b0 = n_bytes, d0 = n_done;
        send_sync(0);
        send_byte(8'h3C, 0);
        for (int i = 0; i < 3; i++) send_bit(1'b1, 0);
        drive(1'b0, 1'b0);       // SE0 at data bit 3
        drive(1'b0, 1'b0);
        idle_bits(4);
        check("R8 partial dropped", n_bytes - b0, 1);
        check_bytes("R8 byte value", b0, d, 1);
        check("R8 pkt_done", n_done - d0, 1);
    endtask

    task automatic t_overflow();
        logic [7:0] d [] = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08};
        int b0 = n_bytes, d0 = n_done, o0 = n_ovf;
        send_sync(0);
        foreach (d[i]) send_byte(d[i], 0);
        send_byte(8'h09, 0);
        send_byte(8'h0A, 0);
        send_eop();
        check("R10 delivered", n_bytes - b0, BUFN);
        check_bytes("R10 byte value", b0, d, BUFN);
        check("R10 err_overflow", n_ovf - o0, 1);
        check("R10 no pkt_done", n_done - d0, 0);
        check("R10 count", int'(rx_byte_count), BUFN);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        idle_bits(3);
        t_packet("R2 R4 R5 R7 normal", 0, '{8'h2D, 8'h5A, 8'hC3});
        t_packet("R6 stuffing", 0, '{8'hFF, 8'hFF, 8'hE0, 8'h07});
        t_packet("R2 long preamble, R7 count cleared", 3, '{8'h69});
        t_sync_error();
        t_se0_bit0();
        t_mid_se0();
        t_overflow();
        t_packet("R10 recovery", 0, '{8'h7E, 8'h81});
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule